// File: doc/BRIEF.md
# Key-Protected Diagnostic Access Window

This block is a small host-facing register window through which diagnostic software reaches dword locations on an internal bus. It holds one base-address register and one data window. Both are shared by the two host functions that can issue accesses. A read or write of the data window through I/O space becomes a single internal-bus transfer at the address held in the base register. The host handshake stays stalled until the internal bus answers.

Writes through the data window are guarded twice. A multi-byte key has to be written, one byte at a time, to a sequence register. A write-enable bit in the control register also has to be set. Any other byte written to the sequence register locks the window again. A write attempted while locked is dropped and sets a sticky error flag. The data window does not answer memory-space accesses in the normal way: reads return all ones and writes do nothing. Function 1 cannot change the base register.

Register offsets (dword aligned, all other offsets read zero and ignore writes): 0x0 data window, 0x4 base, 0x8 key sequence, 0xC control. Control bits: bit 0 unlocked status (read only), bit 4 write enable, bit 7 sticky error (write one to clear).

Top module: `diag_window`

## Requirements
- R1: After reset the base register, write enable, error flag and key matcher are all zero, so reads of offsets 0x4 and 0xC return 0 and no internal-bus request is issued.
- R2: A write to offset 0x4 stores only bits 31 down to WIN_BITS (default 20, mask 0xFFF00000); all lower bits read back as zero.
- R3: A write to offset 0x4 from function 1 (hostFunc=1) is dropped and the base is unchanged; function 0 writes take effect.
- R4: An access to offset 0x0 with hostIsIo=0 issues no internal-bus request, completes at once, reads 0xFFFFFFFF, and a write leaves internal memory unchanged.
- R5: An I/O-space read of offset 0x0 issues exactly one internal-bus read at busAddr equal to the base register, holds hostReady low until busValid, and returns busRdata.
- R6: An I/O-space write of offset 0x0 issues one internal-bus write of hostWdata at the base address only when the window is unlocked and control bit 4 is set; otherwise no request is issued.
- R7: The window unlocks after KEY_LEN writes to offset 0x8 whose low bytes equal the key bytes in order, least significant key byte first (default 0xA5, 0x3C, 0x96); a wrong byte returns the matcher to its first step, and control bit 0 shows the unlocked state.
- R8: Any write to offset 0x8 while unlocked clears the unlocked state at once. That byte is taken as a new first step, which advances only if it equals the first key byte.
- R9: An I/O-space write to offset 0x0 while locked or with bit 4 clear is discarded and sets control bit 7, which stays set until a control write with bit 7 = 1.
- R10: Both functions read the same shared base, and I/O-space data-window accesses from function 1 reach the same internal location as those from function 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostValid | input | 1 | Host access request, held until hostReady |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostIsIo | input | 1 | 1 = I/O space, 0 = memory space |
| hostFunc | input | 1 | Issuing host function (0 or 1) |
| hostAddr | input | ADDR_W | Register byte offset |
| hostWdata | input | 32 | Write data |
| hostReady | output | 1 | Access complete this cycle |
| hostRdata | output | 32 | Read data, valid with hostReady |
| busReq | output | 1 | Internal-bus request pulse |
| busWrite | output | 1 | Request is a write |
| busAddr | output | 32 | Internal-bus address (the base register) |
| busWdata | output | 32 | Internal-bus write data |
| busValid | input | 1 | Internal-bus response valid |
| busRdata | input | 32 | Internal-bus read data |

## Verification
The key matcher, the write-enable bit, the error flag and the base register are held state. None of them can be observed directly, so the bench reads each back through offsets 0xC and 0x4 right after the stimulus that could disturb it. A matcher stuck one step out appears as a wrong bit 0 on the next control read. It also appears as an unexpected or missing bus request on the next data write, which the bench detects in that same cycle. A handshake fault shows as hostReady rising before or after the cycle in which busValid arrives, for internal-bus latencies of one to three cycles.

// File: rtl/diag_win_pkg.sv
package diag_win_pkg;
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_BASE = 2'd1,
    REG_KEY  = 2'd2,
    REG_CTL  = 2'd3
  } regSel_e;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_ONES,
    RD_BASE,
    RD_CTL,
    RD_BUS
  } rdSel_e;

  typedef struct packed {
    logic   baseWe;
    logic   ctlWe;
    logic   errSet;
    rdSel_e rdSel;
  } ctlStrobes_t;

  localparam int CTL_UNLK_BIT = 0;
  localparam int CTL_EN_BIT   = 4;
  localparam int CTL_ERR_BIT  = 7;
endpackage

// File: rtl/diag_win_ctrl.sv
module diag_win_ctrl
  import diag_win_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int KEY_LEN = 3,
  parameter logic [KEY_LEN*8-1:0] KEY = 24'h963CA5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostValid,
  input  logic              hostWrite,
  input  logic              hostIsIo,
  input  logic              hostFunc,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [7:0]        keyByte,
  input  logic              diagEn,
  input  logic              busValid,
  output logic              busReq,
  output logic              busWrite,
  output logic              hostReady,
  output logic              unlocked,
  output ctlStrobes_t       strobes
);
  localparam int STEP_W = $clog2(KEY_LEN + 1);

  typedef enum logic {ST_IDLE, ST_WAIT} state_e;

  state_e               state;
  logic [STEP_W-1:0]    step;
  logic                 mapped, accept, dataIo, writeOk, keyWr;
  regSel_e              regSel;
  logic [KEY_LEN*8-1:0] keyShift;
  logic [7:0]           keyWant;

  assign mapped   = (hostAddr[ADDR_W-1:4] == '0) && (hostAddr[1:0] == 2'b00);
  assign regSel   = regSel_e'(hostAddr[3:2]);
  assign unlocked = (step == STEP_W'(KEY_LEN));
  assign keyShift = KEY >> (32'(step) << 3);
  assign keyWant  = keyShift[7:0];

  always_comb begin
    accept    = (state == ST_IDLE) && hostValid;
    dataIo    = accept && mapped && (regSel == REG_DATA) && hostIsIo;
    writeOk   = unlocked && diagEn;
    keyWr     = accept && hostWrite && mapped && (regSel == REG_KEY);
    busReq    = dataIo && (!hostWrite || writeOk);
    busWrite  = busReq && hostWrite;
    hostReady = (accept && !busReq) || ((state == ST_WAIT) && busValid);

    strobes.baseWe = accept && hostWrite && mapped && (regSel == REG_BASE) && !hostFunc;
    strobes.ctlWe  = accept && hostWrite && mapped && (regSel == REG_CTL);
    strobes.errSet = dataIo && hostWrite && !writeOk;

    if (state == ST_WAIT)  strobes.rdSel = RD_BUS;
    else if (!mapped)      strobes.rdSel = RD_ZERO;
    else begin
      unique case (regSel)
        REG_DATA: strobes.rdSel = hostIsIo ? RD_ZERO : RD_ONES;
        REG_BASE: strobes.rdSel = RD_BASE;
        REG_CTL:  strobes.rdSel = RD_CTL;
        default:  strobes.rdSel = RD_ZERO;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (busReq)   state <= ST_WAIT;
        ST_WAIT: if (busValid) state <= ST_IDLE;
        default:               state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step <= '0;
    end else if (keyWr) begin
      if (unlocked)                 step <= (keyByte == KEY[7:0]) ? STEP_W'(1) : '0;
      else if (keyByte == keyWant)  step <= step + 1'b1;
      else                          step <= '0;
    end
  end

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rstN)
    busReq |=> !busReq); // R5
  AST_WAIT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !busValid) |-> !hostReady); // R5
  AST_MEM_NO_BUS: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && !hostIsIo) |-> !busReq); // R4
  AST_RELOCK: assert property (@(posedge clk) disable iff (!rstN)
    (keyWr && unlocked) |=> !unlocked); // R8
endmodule

// File: rtl/diag_win_dp.sv
module diag_win_dp
  import diag_win_pkg::*;
#(
  parameter int WIN_BITS = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strobes,
  input  logic        unlocked,
  input  logic [31:0] hostWdata,
  input  logic [31:0] busRdata,
  output logic [31:0] hostRdata,
  output logic [31:0] busAddr,
  output logic [31:0] busWdata,
  output logic        diagEn
);
  localparam logic [31:0] BASE_MASK = ~((32'h1 << WIN_BITS) - 32'h1);

  logic [31:0] baseReg;
  logic        errReg, errClr;
  logic [31:0] ctlView;

  assign errClr   = strobes.ctlWe && hostWdata[CTL_ERR_BIT];
  assign busAddr  = baseReg;
  assign busWdata = hostWdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg <= '0;
      diagEn  <= 1'b0;
      errReg  <= 1'b0;
    end else begin
      if (strobes.baseWe) baseReg <= hostWdata & BASE_MASK;
      if (strobes.ctlWe)  diagEn  <= hostWdata[CTL_EN_BIT];
      if (strobes.errSet) errReg  <= 1'b1;
      else if (errClr)    errReg  <= 1'b0;
    end
  end

  always_comb begin
    ctlView               = '0;
    ctlView[CTL_UNLK_BIT] = unlocked;
    ctlView[CTL_EN_BIT]   = diagEn;
    ctlView[CTL_ERR_BIT]  = errReg;
    unique case (strobes.rdSel)
      RD_ONES: hostRdata = 32'hFFFF_FFFF;
      RD_BASE: hostRdata = baseReg;
      RD_CTL:  hostRdata = ctlView;
      RD_BUS:  hostRdata = busRdata;
      default: hostRdata = '0;
    endcase
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (errReg && !errClr) |=> errReg); // R9
  AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.errSet |=> errReg); // R9
endmodule

// File: rtl/diag_window.sv
module diag_window
  import diag_win_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WIN_BITS = 20,
  parameter int KEY_LEN = 3,
  parameter logic [KEY_LEN*8-1:0] KEY = 24'h963CA5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostValid,
  input  logic              hostWrite,
  input  logic              hostIsIo,
  input  logic              hostFunc,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWdata,
  output logic              hostReady,
  output logic [31:0]       hostRdata,
  output logic              busReq,
  output logic              busWrite,
  output logic [31:0]       busAddr,
  output logic [31:0]       busWdata,
  input  logic              busValid,
  input  logic [31:0]       busRdata
);
  ctlStrobes_t strobes;
  logic        unlocked, diagEn;

  diag_win_ctrl #(.ADDR_W(ADDR_W), .KEY_LEN(KEY_LEN), .KEY(KEY)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostWrite(hostWrite),
    .hostIsIo(hostIsIo), .hostFunc(hostFunc), .hostAddr(hostAddr),
    .keyByte(hostWdata[7:0]), .diagEn(diagEn), .busValid(busValid),
    .busReq(busReq), .busWrite(busWrite), .hostReady(hostReady),
    .unlocked(unlocked), .strobes(strobes)
  );

  diag_win_dp #(.WIN_BITS(WIN_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .unlocked(unlocked),
    .hostWdata(hostWdata), .busRdata(busRdata), .hostRdata(hostRdata),
    .busAddr(busAddr), .busWdata(busWdata), .diagEn(diagEn)
  );

  AST_F1_BASE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && hostWrite && hostFunc) |=> $stable(busAddr)); // R3
endmodule

// File: tb/sim_diag_window.sv
`timescale 1ns/1ps
module sim_diag_window;
  localparam int ADDR_W = 8;
  localparam int WIN_BITS = 20;
  localparam int KEY_LEN = 3;
  localparam logic [KEY_LEN*8-1:0] KEY = 24'h963CA5;
  localparam logic [31:0] MASK = 32'hFFF0_0000;

  logic clk = 1'b0, rstN = 1'b0;
  logic hostValid = 1'b0, hostWrite = 1'b0, hostIsIo = 1'b0, hostFunc = 1'b0;
  logic [ADDR_W-1:0] hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic hostReady, busReq, busWrite;
  logic [31:0] hostRdata, busAddr, busWdata;
  logic busValid = 1'b0;
  logic [31:0] busRdata = '0;

  always #2.5 clk = ~clk;

  diag_window #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .KEY_LEN(KEY_LEN), .KEY(KEY)) u0 (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostWrite(hostWrite),
    .hostIsIo(hostIsIo), .hostFunc(hostFunc), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostReady(hostReady), .hostRdata(hostRdata),
    .busReq(busReq), .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busValid(busValid), .busRdata(busRdata)
  );

  int total = 0, bad = 0;

  // Internal-bus stub with adjustable latency
  logic [31:0] sMem [logic [31:0]];
  int stubLat = 1;
  int cnt = 0;
  logic pend = 1'b0, pW = 1'b0;
  logic [31:0] pA = '0, pD = '0;
  always @(posedge clk) begin
    if (busReq) begin
      pend <= 1'b1; pW <= busWrite; pA <= busAddr; pD <= busWdata;
      cnt <= stubLat; busValid <= 1'b0;
    end else if (pend) begin
      if (cnt == 1) begin
        busValid <= 1'b1;
        busRdata <= sMem.exists(pA) ? sMem[pA] : 32'h0;
        if (pW) sMem[pA] = pD;
        pend <= 1'b0;
      end else cnt <= cnt - 1;
    end else busValid <= 1'b0;
  end

  // Behavioural reference model
  logic [31:0] mBase = '0;
  bit mEn = 0, mErr = 0;
  int mStep = 0;
  logic [31:0] mMem [logic [31:0]];
  bit expectBus = 0;
  int reqSeen = 0;

  function automatic logic [31:0] mRead(bit io, logic [7:0] a);
    logic [31:0] v;
    case (a)
      8'h00: v = io ? (mMem.exists(mBase) ? mMem[mBase] : 32'h0) : 32'hFFFF_FFFF;
      8'h04: v = mBase;
      8'h0C: v = {24'h0, mErr, 2'b00, mEn, 3'b000, (mStep == KEY_LEN)};
      default: v = 32'h0;
    endcase
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Request monitor, every cycle
  always begin
    @(negedge clk); #2;
    if (busReq) begin
      reqSeen++;
      if (!expectBus) begin
        total++; bad++;
        $display("FAIL R4/R6 unexpected bus request act=1 exp=0 addr=%h", busAddr);
      end else begin
        chk("R5/R6 busAddr equals base", busAddr, mBase);
        if (busWrite) chk("R6 busWdata", busWdata, hostWdata);
      end
    end
  end

  task automatic acc(input string tag, input bit wr, input bit io, input bit fn,
                     input logic [7:0] a, input logic [31:0] wd);
    logic [31:0] exp, rd;
    int lowCnt;
    bit ok, bus;
    ok  = (mStep == KEY_LEN) && mEn;
    bus = (a == 8'h00) && io && (!wr || ok);
    exp = mRead(io, a);
    @(negedge clk);
    expectBus = bus; reqSeen = 0;
    hostValid = 1; hostWrite = wr; hostIsIo = io; hostFunc = fn;
    hostAddr = a; hostWdata = wd;
    lowCnt = 0; rd = '0;
    for (int g = 0; g < 40; g++) begin
      #2;
      if (hostReady) begin rd = hostRdata; break; end
      lowCnt++;
      @(negedge clk);
    end
    @(negedge clk);
    hostValid = 0;
    #2;
    expectBus = 0;
    if (!wr) chk({tag, " read data"}, rd, exp);
    chk({tag, " request count"}, reqSeen, bus ? 1 : 0);
    chk({tag, " ready timing R5"}, lowCnt, bus ? stubLat + 1 : 0);
    if (wr) begin
      case (a)
        8'h04: if (!fn) mBase = wd & MASK;
        8'h08: begin
          if (mStep == KEY_LEN) mStep = (wd[7:0] == KEY[7:0]) ? 1 : 0;
          else if (wd[7:0] == KEY[8*mStep +: 8]) mStep++;
          else mStep = 0;
        end
        8'h0C: begin mEn = wd[4]; if (wd[7]) mErr = 0; end
        8'h00: if (io) begin
          if (ok) mMem[mBase] = wd; else mErr = 1;
        end
        default: ;
      endcase
    end
  endtask

  task automatic sendKey();
    for (int i = 0; i < KEY_LEN; i++) acc("R7 key byte", 1, 1, 0, 8'h08, {24'h0, KEY[8*i +: 8]});
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 no request in reset", {31'h0, busReq}, 32'h0);
    rstN = 1;
    acc("R1 base after reset", 0, 1, 0, 8'h04, 0);
    acc("R1 control after reset", 0, 0, 0, 8'h0C, 0);
    acc("R4 memory-space data read", 0, 0, 0, 8'h00, 0);

    acc("R2 base write all ones", 1, 1, 0, 8'h04, 32'hFFFF_FFFF);
    acc("R2 base readback", 0, 1, 0, 8'h04, 0);
    acc("R3 function1 base write", 1, 0, 1, 8'h04, 32'h1234_0000);
    acc("R3 base unchanged", 0, 1, 1, 8'h04, 0);
    acc("R2 base write f0", 1, 1, 0, 8'h04, 32'h1234_5678);
    acc("R2 masked base", 0, 0, 0, 8'h04, 0);

    sMem[32'h1230_0000] = 32'hDEAD_BEEF;
    mMem[32'h1230_0000] = 32'hDEAD_BEEF;
    stubLat = 2;
    acc("R5 io read f0", 0, 1, 0, 8'h00, 0);
    stubLat = 1;
    acc("R10 io read f1", 0, 1, 1, 8'h00, 0);

    acc("R4 memory-space data write", 1, 0, 0, 8'h00, 32'h1111_1111);
    acc("R4 memory unchanged", 0, 1, 0, 8'h00, 0);
    acc("R9 locked io write", 1, 1, 0, 8'h00, 32'h2222_2222);
    acc("R9 error bit set", 0, 1, 0, 8'h0C, 0);
    acc("R9 memory unchanged", 0, 1, 0, 8'h00, 0);

    acc("R6 enable only", 1, 1, 0, 8'h0C, 32'h10);
    acc("R6 write with enable but locked", 1, 1, 0, 8'h00, 32'h3333_3333);
    sendKey();
    acc("R7 unlocked status", 0, 1, 0, 8'h0C, 0);
    stubLat = 3;
    acc("R6 unlocked write", 1, 1, 0, 8'h00, 32'h4444_4444);
    acc("R6 write landed", 0, 1, 0, 8'h00, 0);
    stubLat = 1;
    acc("R10 f1 unlocked write", 1, 1, 1, 8'h00, 32'h5555_5555);
    acc("R10 f0 sees f1 write", 0, 1, 0, 8'h00, 0);

    acc("R8 wrong byte relocks", 1, 1, 0, 8'h08, 32'h0000_0077);
    acc("R8 status cleared", 0, 1, 0, 8'h0C, 0);
    acc("R8 write after relock", 1, 1, 0, 8'h00, 32'h6666_6666);
    acc("R8 memory unchanged", 0, 1, 0, 8'h00, 0);

    acc("R9 clear error", 1, 1, 0, 8'h0C, 32'h90);
    acc("R9 error cleared", 0, 1, 0, 8'h0C, 0);

    acc("R7 byte0", 1, 1, 0, 8'h08, {24'h0, KEY[7:0]});
    acc("R7 byte1", 1, 1, 0, 8'h08, {24'h0, KEY[15:8]});
    acc("R7 bad byte", 1, 1, 0, 8'h08, 32'h0000_0000);
    acc("R7 byte2 alone", 1, 1, 0, 8'h08, {24'h0, KEY[23:16]});
    acc("R7 not unlocked", 0, 1, 0, 8'h0C, 0);
    sendKey();
    acc("R7 unlocked again", 0, 1, 0, 8'h0C, 0);

    acc("R8 first key byte while unlocked", 1, 1, 0, 8'h08, {24'h0, KEY[7:0]});
    acc("R8 locked after restart", 0, 1, 0, 8'h0C, 0);
    acc("R8 byte1", 1, 1, 0, 8'h08, {24'h0, KEY[15:8]});
    acc("R8 byte2", 1, 1, 0, 8'h08, {24'h0, KEY[23:16]});
    acc("R8 unlocked from restart", 0, 1, 0, 8'h0C, 0);

    acc("R6 clear enable", 1, 1, 0, 8'h0C, 32'h0);
    acc("R6 write with enable clear", 1, 1, 0, 8'h00, 32'h7777_7777);
    acc("R6 memory unchanged", 0, 1, 0, 8'h00, 0);
    acc("R9 error after enable-clear write", 0, 1, 0, 8'h0C, 0);
    acc("R1 unmapped offset reads zero", 0, 1, 0, 8'h40, 0);

    summary();
    $finish;
  end
endmodule